// File: doc/BRIEF.md
# Multi-Signal Trigger Condition Evaluator

This block decides, on every clock, whether a set of probed design signals meets a trigger condition that software programs at run time. Two kinds of probe exist. Each wide probe is compared for exact equality against its own programmed value. Each single-bit probe is tested for a level (low or high) or for an edge (rising or falling). Any subset of these terms can be switched on. The enabled terms are joined by one operator, AND or OR, which applies to all of them.

A capture controller raises `arm` while it waits for an event. The first cycle in which the condition holds while armed produces a single-cycle pulse on `trig_hit`, one clock after the matching sample. Dropping `arm` rearms the evaluator for the next pulse. Configuration is written through a small register port, and writes are taken only while the evaluator is disarmed.

Top module: `trg_cond_eval`

## Requirements
- R1: After reset `trig_hit` is 0, the operator is AND, both enable masks are 0, every compare value is 0, every bit mode is 00 and the previous-sample register is 0.
- R2: A wide term matches only when its probe equals its programmed compare value on every bit.
- R3: A single-bit term with mode 00 matches while its probe is 0, and with mode 01 it matches while its probe is 1.
- R4: A single-bit term with mode 11 matches when its probe is 1 and was 0 one cycle earlier (rising edge). Mode 10 matches when the probe is 0 and was 1 one cycle earlier (falling edge).
- R5: With operator AND (op bit 0 = 0), the condition holds only when every enabled term matches. Disabled terms do not block it.
- R6: With operator OR (op bit 0 = 1), the condition holds when any enabled term matches. A matching disabled term does not make it hold.
- R7: When no term is enabled, `trig_hit` stays 0 under either operator, whatever the probes carry.
- R8: `trig_hit` is 1 in the cycle after a sample in which `arm` was 1 and the condition held. It is never 1 after a sample taken with `arm` at 0.
- R9: Each period of `arm` at 1 produces at most one pulse, lasting a single cycle. Driving `arm` to 0 for at least one cycle allows a new pulse.
- R10: Register map: address 0 holds the operator in bit 0; address 1 holds the wide-term enables (bit i = wide term i); address 2 holds the single-bit enables (bit j = bit term j); address 8+i holds the compare value of wide term i; address 16+j holds the 2-bit mode of bit term j. A write is taken when `cfg_we` is 1 and `arm` is 0. Writes made while `arm` is 1 are discarded.
- R11: A compare value keeps only the low WIDE_W bits of the written data. Writing 0xC5 with WIDE_W = 6 matches a probe value of 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Evaluator armed; also blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| wide_probe | input | N_WIDE*WIDE_W | Wide probes; term i occupies bits i*WIDE_W upward |
| bit_probe | input | N_BIT | Single-bit probes |
| trig_hit | output | 1 | Single-cycle trigger pulse, registered |

## Verification
The assertions assume that `arm` is a clean level from the capture controller that is held for whole cycles. They also assume that the register port is used for setup only, so the configuration seen while armed is whatever was last written while disarmed. The bench drives every input at the falling clock edge. It writes registers only with `arm` low, except in the one scenario that deliberately writes while armed to show the write is lost. It disarms for at least one cycle between scenarios, so each pulse is attributable to exactly one arming period.

// File: rtl/trg_pkg.sv
package trg_pkg;

  typedef enum logic [1:0] {
    BM_LOW  = 2'b00,
    BM_HIGH = 2'b01,
    BM_FALL = 2'b10,
    BM_RISE = 2'b11
  } bit_mode_e;

  localparam logic OP_AND = 1'b0;
  localparam logic OP_OR  = 1'b1;

  // Level or edge test of one single-bit probe against the previous sample.
  function automatic logic bit_term(bit_mode_e m, logic cur, logic prev);
    case (m)
      BM_LOW:  return !cur;
      BM_HIGH: return cur;
      BM_FALL: return prev && !cur;
      default: return !prev && cur;
    endcase
  endfunction

endpackage

// File: rtl/trg_cfg_regs.sv
module trg_cfg_regs
  import trg_pkg::*;
#(
  parameter int N_WIDE = 2,
  parameter int WIDE_W = 6,
  parameter int N_BIT  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic                       op,
  output logic [N_WIDE-1:0]          wide_en,
  output logic [N_BIT-1:0]           bit_en,
  output logic [N_WIDE*WIDE_W-1:0]   wide_val,
  output logic [2*N_BIT-1:0]         bit_mode
);

  localparam logic [ADDR_W-1:0] A_OP    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_WEN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_BEN   = ADDR_W'(2);
  localparam int                A_VAL0  = 8;
  localparam int                A_MODE0 = 16;

  logic wr_ok;
  assign wr_ok = cfg_we && !arm;

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op      <= OP_AND;
      wide_en <= '0;
      bit_en  <= '0;
    end else if (wr_ok) begin
      if (cfg_addr == A_OP)  op      <= cfg_wdata[0];
      if (cfg_addr == A_WEN) wide_en <= cfg_wdata[N_WIDE-1:0];
      if (cfg_addr == A_BEN) bit_en  <= cfg_wdata[N_BIT-1:0];
    end
  end

  for (genvar i = 0; i < N_WIDE; i++) begin : g_val
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wide_val[i*WIDE_W +: WIDE_W] <= '0;
      else if (wr_ok && cfg_addr == ADDR_W'(A_VAL0 + i))
        wide_val[i*WIDE_W +: WIDE_W] <= cfg_wdata[WIDE_W-1:0];
    end
  end

  for (genvar j = 0; j < N_BIT; j++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bit_mode[2*j +: 2] <= BM_LOW;
      else if (wr_ok && cfg_addr == ADDR_W'(A_MODE0 + j))
        bit_mode[2*j +: 2] <= cfg_wdata[1:0];
    end
  end

endmodule

// File: rtl/trg_term_eval.sv
module trg_term_eval
  import trg_pkg::*;
#(
  parameter int N_WIDE = 2,
  parameter int WIDE_W = 6,
  parameter int N_BIT  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_WIDE*WIDE_W-1:0] wide_probe,
  input  logic [N_BIT-1:0]         bit_probe,
  input  logic [N_WIDE*WIDE_W-1:0] wide_val,
  input  logic [2*N_BIT-1:0]       bit_mode,
  output logic [N_WIDE-1:0]        wide_hit,
  output logic [N_BIT-1:0]         bit_hit
);

  function automatic logic wide_eq(logic [WIDE_W-1:0] smp, logic [WIDE_W-1:0] ref_v);
    return smp == ref_v;
  endfunction

  logic [N_BIT-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= bit_probe;
  end

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    assign wide_hit[i] = wide_eq(wide_probe[i*WIDE_W +: WIDE_W],
                                 wide_val[i*WIDE_W +: WIDE_W]);
  end

  for (genvar j = 0; j < N_BIT; j++) begin : g_bit
    assign bit_hit[j] = bit_term(bit_mode_e'(bit_mode[2*j +: 2]),
                                 bit_probe[j], prev_q[j]);
  end

endmodule

// File: rtl/trg_combine.sv
module trg_combine
  import trg_pkg::*;
#(
  parameter int NT = 5
) (
  input  logic          op,
  input  logic [NT-1:0] hits,
  input  logic [NT-1:0] en,
  output logic          cond,
  output logic          any_en
);

  // Disabled terms take the identity of the operator: 1 for AND, 0 for OR.
  function automatic logic join_terms(logic o, logic [NT-1:0] h, logic [NT-1:0] e);
    if (o == OP_OR) return |(h & e);
    else            return &(h | ~e);
  endfunction

  assign any_en = |en;
  assign cond   = any_en && join_terms(op, hits, en);

endmodule

// File: rtl/trg_cond_eval.sv
module trg_cond_eval
  import trg_pkg::*;
#(
  parameter int N_WIDE = 2,
  parameter int WIDE_W = 6,
  parameter int N_BIT  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic [N_WIDE*WIDE_W-1:0] wide_probe,
  input  logic [N_BIT-1:0]         bit_probe,
  output logic                     trig_hit
);

  localparam int NT = N_WIDE + N_BIT;

  logic                     cfg_op;
  logic [N_WIDE-1:0]        wide_en;
  logic [N_BIT-1:0]         bit_en;
  logic [N_WIDE*WIDE_W-1:0] wide_val;
  logic [2*N_BIT-1:0]       bit_mode;
  logic [N_WIDE-1:0]        wide_hit;
  logic [N_BIT-1:0]         bit_hit;
  logic                     cond_w;
  logic                     any_en_w;
  logic                     fire_w;
  logic                     fired_q;
  logic                     hit_q;

  trg_cfg_regs #(
    .N_WIDE(N_WIDE), .WIDE_W(WIDE_W), .N_BIT(N_BIT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .op(cfg_op), .wide_en(wide_en), .bit_en(bit_en),
    .wide_val(wide_val), .bit_mode(bit_mode)
  );

  trg_term_eval #(
    .N_WIDE(N_WIDE), .WIDE_W(WIDE_W), .N_BIT(N_BIT)
  ) i_terms (
    .clk(clk), .rst_n(rst_n),
    .wide_probe(wide_probe), .bit_probe(bit_probe),
    .wide_val(wide_val), .bit_mode(bit_mode),
    .wide_hit(wide_hit), .bit_hit(bit_hit)
  );

  trg_combine #(.NT(NT)) i_join (
    .op(cfg_op),
    .hits({bit_hit, wide_hit}),
    .en({bit_en, wide_en}),
    .cond(cond_w),
    .any_en(any_en_w)
  );

  // One pulse per arming period; disarming clears the fired flag.
  assign fire_w = arm && !fired_q && cond_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      hit_q   <= fire_w;
      fired_q <= arm && (fired_q || cond_w);
    end
  end

  assign trig_hit = hit_q;

endmodule

// File: rtl/trg_cond_eval_chk.sv
module trg_cond_eval_chk #(
  parameter int N_WIDE = 2,
  parameter int WIDE_W = 6,
  parameter int N_BIT  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     arm,
  input logic                     trig_hit,
  input logic                     cond,
  input logic                     any_en,
  input logic                     op,
  input logic [N_WIDE-1:0]        wide_en,
  input logic [N_BIT-1:0]         bit_en,
  input logic [N_WIDE*WIDE_W-1:0] wide_val,
  input logic [2*N_BIT-1:0]       bit_mode
);

  AST_HIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n) trig_hit |-> $past(arm)); // R8
  AST_HIT_FOLLOWS_COND: assert property (@(posedge clk) disable iff (!rst_n) trig_hit |-> $past(cond)); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) trig_hit |=> !trig_hit); // R9
  AST_NO_TERM_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !any_en |=> !trig_hit); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) $past(arm) |-> $stable({op, wide_en, bit_en, wide_val, bit_mode})); // R10

endmodule

bind trg_cond_eval trg_cond_eval_chk #(
  .N_WIDE(N_WIDE), .WIDE_W(WIDE_W), .N_BIT(N_BIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .trig_hit(trig_hit),
  .cond(cond_w), .any_en(any_en_w), .op(cfg_op),
  .wide_en(wide_en), .bit_en(bit_en), .wide_val(wide_val), .bit_mode(bit_mode)
);

// File: tb/test_trg_cond_eval.sv
module test_trg_cond_eval;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [11:0] wide_probe = '0;
  logic [2:0]  bit_probe = '0;
  logic        trig_hit;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trg_cond_eval i_trg_cond_eval (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .wide_probe(wide_probe), .bit_probe(bit_probe), .trig_hit(trig_hit)
  );

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: trig_hit=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_all(logic o, logic [7:0] wm, logic [7:0] bm);
    wr(5'd0, {7'd0, o});
    wr(5'd1, wm);
    wr(5'd2, bm);
  endtask

  // Apply one sample, then read the registered result one cycle later.
  task automatic cyc(logic [5:0] w0, logic [5:0] w1, logic [2:0] b, logic a,
                     string req, logic exp);
    wide_probe = {w1, w0}; bit_probe = b; arm = a;
    @(negedge clk);
    chk(req, trig_hit, exp);
  endtask

  task automatic t_reset;
    chk("R1", trig_hit, 1'b0);
    cyc(6'h00, 6'h00, 3'b000, 1'b1, "R7", 1'b0);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R1", 1'b0);
    wr(5'd1, 8'h01);
    cyc(6'h00, 6'h15, 3'b000, 1'b1, "R1", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R1", 1'b0);
  endtask

  task automatic t_equality;
    cfg_all(1'b0, 8'h01, 8'h00);
    wr(5'd8, 8'h2A);
    cyc(6'h2B, 6'h00, 3'b000, 1'b1, "R2", 1'b0);
    cyc(6'h2A, 6'h00, 3'b000, 1'b1, "R2", 1'b1);
    cyc(6'h2A, 6'h00, 3'b000, 1'b1, "R9", 1'b0);
    cyc(6'h2A, 6'h00, 3'b000, 1'b1, "R9", 1'b0);
    cyc(6'h2A, 6'h00, 3'b000, 1'b0, "R8", 1'b0);
    cyc(6'h2A, 6'h00, 3'b000, 1'b1, "R9", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R8", 1'b0);
  endtask

  task automatic t_level;
    cfg_all(1'b0, 8'h00, 8'h02);
    wr(5'd17, 8'h01);
    cyc(6'h00, 6'h00, 3'b000, 1'b1, "R3", 1'b0);
    cyc(6'h00, 6'h00, 3'b010, 1'b1, "R3", 1'b1);
    cyc(6'h00, 6'h00, 3'b010, 1'b0, "R3", 1'b0);
    wr(5'd17, 8'h00);
    cyc(6'h00, 6'h00, 3'b010, 1'b1, "R3", 1'b0);
    cyc(6'h00, 6'h00, 3'b000, 1'b1, "R3", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R3", 1'b0);
  endtask

  task automatic t_edge;
    cfg_all(1'b0, 8'h00, 8'h04);
    wr(5'd18, 8'h03);
    cyc(6'h00, 6'h00, 3'b100, 1'b0, "R4", 1'b0);
    cyc(6'h00, 6'h00, 3'b100, 1'b1, "R4", 1'b0);
    cyc(6'h00, 6'h00, 3'b000, 1'b1, "R4", 1'b0);
    cyc(6'h00, 6'h00, 3'b100, 1'b1, "R4", 1'b1);
    cyc(6'h00, 6'h00, 3'b100, 1'b0, "R4", 1'b0);
    wr(5'd18, 8'h02);
    cyc(6'h00, 6'h00, 3'b100, 1'b1, "R4", 1'b0);
    cyc(6'h00, 6'h00, 3'b000, 1'b1, "R4", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R4", 1'b0);
  endtask

  task automatic t_and;
    wr(5'd8, 8'h11);
    wr(5'd9, 8'h05);
    wr(5'd16, 8'h01);
    cfg_all(1'b0, 8'h03, 8'h01);
    cyc(6'h11, 6'h05, 3'b000, 1'b1, "R5", 1'b0);
    cyc(6'h11, 6'h00, 3'b001, 1'b1, "R5", 1'b0);
    cyc(6'h11, 6'h05, 3'b001, 1'b1, "R5", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R5", 1'b0);
    cfg_all(1'b0, 8'h01, 8'h01);
    cyc(6'h11, 6'h3F, 3'b001, 1'b1, "R5", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R5", 1'b0);
  endtask

  task automatic t_or;
    cfg_all(1'b1, 8'h03, 8'h01);
    cyc(6'h00, 6'h00, 3'b000, 1'b1, "R6", 1'b0);
    cyc(6'h00, 6'h05, 3'b000, 1'b1, "R6", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R6", 1'b0);
    cfg_all(1'b1, 8'h01, 8'h00);
    cyc(6'h00, 6'h05, 3'b001, 1'b1, "R6", 1'b0);
    cyc(6'h11, 6'h00, 3'b000, 1'b1, "R6", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R6", 1'b0);
  endtask

  task automatic t_none;
    cfg_all(1'b0, 8'h00, 8'h00);
    cyc(6'h11, 6'h05, 3'b001, 1'b1, "R7", 1'b0);
    cyc(6'h00, 6'h00, 3'b000, 1'b1, "R7", 1'b0);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R7", 1'b0);
    cfg_all(1'b1, 8'h00, 8'h00);
    cyc(6'h11, 6'h05, 3'b001, 1'b1, "R7", 1'b0);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R7", 1'b0);
  endtask

  task automatic t_frozen;
    cfg_all(1'b0, 8'h01, 8'h00);
    wr(5'd8, 8'h01);
    cyc(6'h00, 6'h00, 3'b000, 1'b1, "R10", 1'b0);
    wr(5'd8, 8'h02);
    wr(5'd1, 8'h00);
    wr(5'd0, 8'h01);
    cyc(6'h02, 6'h00, 3'b000, 1'b1, "R10", 1'b0);
    cyc(6'h01, 6'h00, 3'b000, 1'b1, "R10", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R10", 1'b0);
  endtask

  task automatic t_trunc;
    cfg_all(1'b0, 8'h01, 8'h00);
    wr(5'd8, 8'hC5);
    cyc(6'h05, 6'h00, 3'b000, 1'b1, "R11", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R11", 1'b0);
  endtask

  task automatic t_disarmed;
    cyc(6'h05, 6'h00, 3'b000, 1'b0, "R8", 1'b0);
    cyc(6'h05, 6'h00, 3'b000, 1'b0, "R8", 1'b0);
    cyc(6'h05, 6'h00, 3'b000, 1'b1, "R8", 1'b1);
    cyc(6'h00, 6'h00, 3'b000, 1'b0, "R8", 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", trig_hit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_equality();
    t_level();
    t_edge();
    t_and();
    t_or();
    t_none();
    t_frozen();
    t_trunc();
    t_disarmed();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

endmodule